// File: doc/BRIEF.md
# DMA Write Line Merge Buffer

This block builds the full memory line for a DMA write that lands in cacheable memory. A DMA write often covers only part of a line. The block therefore gathers three versions of the same line and combines them byte by byte:

- the partial write data arriving from the I/O side, with per-byte enables;
- the current copy of the line read from DRAM;
- a possibly dirty copy flushed out of the processor cache.

It then offers the combined line to the memory controller for write-back.

There are two complete buffer sets, used in strict alternation. The I/O side can fill one set while the other is still waiting for its memory read or flush, or is waiting for its write-back. The I/O side writes a line as a series of words and marks the final word. The memory read and the cache flush each arrive as wide beats, addressed to the set that `fill_set` named when the line was opened. The memory controller sees `wb_req` and `wb_set`, and reads the merged beats through `wb_beat`/`wb_data`. It pulses `wb_ack` once the line has been written.

Top module: `dmb_merge_buf`

## Requirements
- R1: After reset, `pci_ready` is 1, `wb_req` is 0 and `fill_set` is 0.
- R2: In the merged line, a byte takes its I/O value wherever any accepted I/O word for that line enabled it. I/O byte k of word w (bits 8k+7:8k of `pci_data`, enabled by `pci_be[k]`) is line byte 8w+k. A later word to the same position overwrites only the bytes it enables.
- R3: A byte not enabled by the I/O side takes the flush value when a dirty flush was delivered (`fl_valid` with `fl_dirty`=1). Otherwise it takes the memory value.
- R4: A flush beat with `fl_dirty`=0 is a cache miss. It completes the flush load, carries no data, and leaves memory data in every byte not enabled by the I/O side.
- R5: `wb_req` for a set rises only once three things have been seen for that set: an I/O word with `pci_last`, a memory beat with `mem_last`, and a flush completion (a miss, or a dirty beat with `fl_last`). These may arrive in any order. The request is visible in the cycle after the clock edge that captured the last of them.
- R6: An accepted I/O word with `pci_last` toggles `fill_set`. The next line is then accepted into the other set while the first set is still collecting or waiting for write-back.
- R7: `pci_ready` is 0 while the set named by `fill_set` has already finished its I/O data and is not yet written back. It returns to 1 in the cycle after the `wb_ack` that frees that set.
- R8: Write-back requests follow allocation order, and `wb_set` names the requesting set. A `wb_ack` frees that set at that clock edge and clears all of its byte enables, so a line reusing the set sees none of the earlier enables.
- R9: Memory and flush beats addressed to a set that has not been opened by I/O data are ignored. They neither store data nor count as a completed load.
- R10: `wb_data` presents merged line bytes 32b to 32b+31 for `wb_beat` = b; byte j of the beat is bits 8j+7:8j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pci_valid | input | 1 | I/O write word valid |
| pci_ready | output | 1 | I/O write word can be accepted |
| pci_word | input | 3 | Word position within the line |
| pci_data | input | 64 | I/O write data |
| pci_be | input | 8 | Byte enables for `pci_data` |
| pci_last | input | 1 | Final I/O word of this line |
| fill_set | output | 1 | Set that the next I/O word goes to |
| mem_valid | input | 1 | Memory read beat valid |
| mem_set | input | 1 | Target set of the memory beat |
| mem_beat | input | 1 | Beat position within the line |
| mem_data | input | 256 | Memory read data |
| mem_last | input | 1 | Final memory beat of the line |
| fl_valid | input | 1 | Flush beat or miss indication valid |
| fl_set | input | 1 | Target set of the flush |
| fl_beat | input | 1 | Beat position within the line |
| fl_dirty | input | 1 | 1: beat carries dirty data; 0: cache miss |
| fl_data | input | 256 | Flushed data |
| fl_last | input | 1 | Final dirty flush beat |
| wb_req | output | 1 | A merged line is ready for write-back |
| wb_set | output | 1 | Set being offered for write-back |
| wb_beat | input | 1 | Beat of the merged line to present |
| wb_data | output | 256 | Merged beat selected by `wb_beat` |
| wb_ack | input | 1 | Write-back done; frees the offered set |

## Verification
The bench builds the block at its default sizes: a 64-byte line, 8-byte I/O words and 32-byte memory beats. This gives eight I/O word positions spread over two beats. A partial word, an overwritten word and an enable in the upper beat can all be set against memory and flush data that differ in every byte. With only two sets, a third line soon runs into back-pressure. This brings within reach the in-order write-back of a set that finished second, and the reuse of a freed set whose previous enables must be gone.

// File: rtl/dmb_pkg.sv
// Shared types for the DMA write merge buffer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package dmb_pkg;

    // Life cycle of one buffer set.
    typedef enum logic [1:0] {
        SET_FREE      = 2'd0,
        SET_COLLECT   = 2'd1,
        SET_WRITEBACK = 2'd2
    } set_state_e;

endpackage

// File: rtl/dmb_merge.sv
// Byte-wise merge of one memory beat from three sources.
// Priority: enabled I/O byte, then flush byte if the flush was dirty, then memory byte.
// Assumes all inputs are slices of the same beat of the same set.
module dmb_merge #(
    parameter int MEM_BYTES = 32
) (
    input  logic [MEM_BYTES*8-1:0] pci_beat,
    input  logic [MEM_BYTES-1:0]   pci_en,
    input  logic [MEM_BYTES*8-1:0] fl_beat,
    input  logic                   fl_dirty,
    input  logic [MEM_BYTES*8-1:0] mem_beat,
    output logic [MEM_BYTES*8-1:0] merged
);

    for (genvar i = 0; i < MEM_BYTES; i++) begin : g_byte
        // Select the winning source for this byte.
        always_comb begin
            if (pci_en[i])
                merged[i*8 +: 8] = pci_beat[i*8 +: 8];
            else if (fl_dirty)
                merged[i*8 +: 8] = fl_beat[i*8 +: 8];
            else
                merged[i*8 +: 8] = mem_beat[i*8 +: 8];
        end
    end

endmodule

// File: rtl/dmb_set.sv
// One buffer set: I/O, memory and flush storage for a line, per-byte enables,
// load completion tracking and the merged read port.
// Assumes pci_we is only asserted while 'accepting' is high (the controller ensures it).
module dmb_set
    import dmb_pkg::*;
#(
    parameter  int LINE_BYTES = 64,
    parameter  int PCI_BYTES  = 8,
    parameter  int MEM_BYTES  = 32,
    localparam int PCI_WORDS  = LINE_BYTES / PCI_BYTES,
    localparam int MEM_BEATS  = LINE_BYTES / MEM_BYTES,
    localparam int PIDX_W     = (PCI_WORDS > 1) ? $clog2(PCI_WORDS) : 1,
    localparam int BEAT_W     = (MEM_BEATS > 1) ? $clog2(MEM_BEATS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pci_we,
    input  logic [PIDX_W-1:0]      pci_idx,
    input  logic [PCI_BYTES*8-1:0] pci_data,
    input  logic [PCI_BYTES-1:0]   pci_be,
    input  logic                   pci_last,
    input  logic                   mem_we,
    input  logic [BEAT_W-1:0]      mem_idx,
    input  logic [MEM_BYTES*8-1:0] mem_data,
    input  logic                   mem_last,
    input  logic                   fl_we,
    input  logic [BEAT_W-1:0]      fl_idx,
    input  logic [MEM_BYTES*8-1:0] fl_data,
    input  logic                   fl_dirty,
    input  logic                   fl_last,
    input  logic                   wb_ack,
    input  logic [BEAT_W-1:0]      rd_idx,
    output logic                   accepting,
    output logic                   wb_pending,
    output logic [MEM_BYTES*8-1:0] rd_data
);

    set_state_e              state_q;
    logic                    pci_done_q, mem_done_q, fl_done_q, dirty_q;
    logic [LINE_BYTES-1:0]   be_q;
    logic [LINE_BYTES*8-1:0] pci_q, mem_q, fl_q;

    logic mem_ok, fl_ok, pci_fin, mem_fin, fl_fin, all_done;
    logic [MEM_BYTES*8-1:0] pci_s, mem_s, fl_s;
    logic [MEM_BYTES-1:0]   be_s;

    // Qualify loads: memory and flush count only while the set collects.
    always_comb begin
        mem_ok   = mem_we && (state_q == SET_COLLECT) && !mem_done_q;
        fl_ok    = fl_we && (state_q == SET_COLLECT) && !fl_done_q;
        pci_fin  = pci_done_q || (pci_we && pci_last);
        mem_fin  = mem_done_q || (mem_ok && mem_last);
        fl_fin   = fl_done_q || (fl_ok && (!fl_dirty || fl_last));
        all_done = pci_fin && mem_fin && fl_fin;
    end

    // Set state, completion flags and byte enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SET_FREE;
            pci_done_q <= 1'b0;
            mem_done_q <= 1'b0;
            fl_done_q  <= 1'b0;
            dirty_q    <= 1'b0;
            be_q       <= '0;
        end else begin
            if (pci_we) begin
                be_q[int'(pci_idx)*PCI_BYTES +: PCI_BYTES] <=
                    be_q[int'(pci_idx)*PCI_BYTES +: PCI_BYTES] | pci_be;
                if (pci_last) pci_done_q <= 1'b1;
            end
            if (mem_ok && mem_last) mem_done_q <= 1'b1;
            if (fl_ok && (!fl_dirty || fl_last)) fl_done_q <= 1'b1;
            if (fl_ok && fl_dirty) dirty_q <= 1'b1;
            case (state_q)
                SET_FREE: begin
                    if (pci_we) state_q <= SET_COLLECT;
                end
                SET_COLLECT: begin
                    if (all_done) state_q <= SET_WRITEBACK;
                end
                SET_WRITEBACK: begin
                    if (wb_ack) begin
                        state_q    <= SET_FREE;
                        pci_done_q <= 1'b0;
                        mem_done_q <= 1'b0;
                        fl_done_q  <= 1'b0;
                        dirty_q    <= 1'b0;
                        be_q       <= '0;
                    end
                end
                default: state_q <= SET_FREE;
            endcase
        end
    end

    // Line data storage; contents are meaningful only under the flags above.
    always_ff @(posedge clk) begin
        if (pci_we) begin
            for (int k = 0; k < PCI_BYTES; k++) begin
                if (pci_be[k])
                    pci_q[(int'(pci_idx)*PCI_BYTES + k)*8 +: 8] <= pci_data[k*8 +: 8];
            end
        end
        if (mem_ok)
            mem_q[int'(mem_idx)*MEM_BYTES*8 +: MEM_BYTES*8] <= mem_data;
        if (fl_ok && fl_dirty)
            fl_q[int'(fl_idx)*MEM_BYTES*8 +: MEM_BYTES*8] <= fl_data;
    end

    // Status seen by the controller.
    always_comb begin
        accepting  = (state_q == SET_FREE) || ((state_q == SET_COLLECT) && !pci_done_q);
        wb_pending = (state_q == SET_WRITEBACK);
    end

    // Slice the addressed beat out of each source.
    always_comb begin
        pci_s = pci_q[int'(rd_idx)*MEM_BYTES*8 +: MEM_BYTES*8];
        mem_s = mem_q[int'(rd_idx)*MEM_BYTES*8 +: MEM_BYTES*8];
        fl_s  = fl_q[int'(rd_idx)*MEM_BYTES*8 +: MEM_BYTES*8];
        be_s  = be_q[int'(rd_idx)*MEM_BYTES +: MEM_BYTES];
    end

    dmb_merge #(.MEM_BYTES(MEM_BYTES)) u_merge (
        .pci_beat (pci_s),
        .pci_en   (be_s),
        .fl_beat  (fl_s),
        .fl_dirty (dirty_q),
        .mem_beat (mem_s),
        .merged   (rd_data)
    );

endmodule

// File: rtl/dmb_ctrl.sv
// Ping-pong control for two buffer sets: fill pointer, write-back pointer,
// I/O back-pressure and routing of write enables and acknowledges.
// Assumes exactly two sets, allocated and retired in strict alternation.
module dmb_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pci_valid,
    input  logic       pci_last,
    input  logic [1:0] accepting,
    input  logic [1:0] pending,
    input  logic       wb_ack,
    output logic       pci_ready,
    output logic [1:0] pci_we_vec,
    output logic [1:0] ack_vec,
    output logic       fill_ptr,
    output logic       wb_ptr,
    output logic       wb_req
);

    logic take;

    // Handshakes against the set each pointer names.
    always_comb begin
        pci_ready = accepting[fill_ptr];
        take      = pci_valid && pci_ready;
        wb_req    = pending[wb_ptr];
    end

    for (genvar s = 0; s < 2; s++) begin : g_route
        // Steer the I/O write and the acknowledge to set s.
        always_comb begin
            pci_we_vec[s] = take && (fill_ptr == 1'(s));
            ack_vec[s]    = wb_ack && wb_req && (wb_ptr == 1'(s));
        end
    end

    // Advance fill pointer at line end, write-back pointer at acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_ptr <= 1'b0;
            wb_ptr   <= 1'b0;
        end else begin
            if (take && pci_last) fill_ptr <= ~fill_ptr;
            if (wb_req && wb_ack) wb_ptr <= ~wb_ptr;
        end
    end

endmodule

// File: rtl/dmb_merge_buf.sv
// Top: two alternating buffer sets merging I/O write data, memory data and
// flushed cache data into one line for write-back.
// Assumes memory and flush beats name the set that fill_set showed when the line opened.
module dmb_merge_buf #(
    parameter  int LINE_BYTES = 64,
    parameter  int PCI_BYTES  = 8,
    parameter  int MEM_BYTES  = 32,
    localparam int PCI_WORDS  = LINE_BYTES / PCI_BYTES,
    localparam int MEM_BEATS  = LINE_BYTES / MEM_BYTES,
    localparam int PIDX_W     = (PCI_WORDS > 1) ? $clog2(PCI_WORDS) : 1,
    localparam int BEAT_W     = (MEM_BEATS > 1) ? $clog2(MEM_BEATS) : 1,
    localparam int MEM_W      = MEM_BYTES * 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pci_valid,
    output logic                   pci_ready,
    input  logic [PIDX_W-1:0]      pci_word,
    input  logic [PCI_BYTES*8-1:0] pci_data,
    input  logic [PCI_BYTES-1:0]   pci_be,
    input  logic                   pci_last,
    output logic                   fill_set,
    input  logic                   mem_valid,
    input  logic                   mem_set,
    input  logic [BEAT_W-1:0]      mem_beat,
    input  logic [MEM_W-1:0]       mem_data,
    input  logic                   mem_last,
    input  logic                   fl_valid,
    input  logic                   fl_set,
    input  logic [BEAT_W-1:0]      fl_beat,
    input  logic                   fl_dirty,
    input  logic [MEM_W-1:0]       fl_data,
    input  logic                   fl_last,
    output logic                   wb_req,
    output logic                   wb_set,
    input  logic [BEAT_W-1:0]      wb_beat,
    output logic [MEM_W-1:0]       wb_data,
    input  logic                   wb_ack
);

    logic [1:0]       accepting, pending, pci_we_vec, ack_vec;
    logic             wb_ptr;
    logic [MEM_W-1:0] rd_data [2];

    dmb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pci_valid  (pci_valid),
        .pci_last   (pci_last),
        .accepting  (accepting),
        .pending    (pending),
        .wb_ack     (wb_ack),
        .pci_ready  (pci_ready),
        .pci_we_vec (pci_we_vec),
        .ack_vec    (ack_vec),
        .fill_ptr   (fill_set),
        .wb_ptr     (wb_ptr),
        .wb_req     (wb_req)
    );

    for (genvar s = 0; s < 2; s++) begin : g_set
        dmb_set #(
            .LINE_BYTES (LINE_BYTES),
            .PCI_BYTES  (PCI_BYTES),
            .MEM_BYTES  (MEM_BYTES)
        ) u_set (
            .clk        (clk),
            .rst_n      (rst_n),
            .pci_we     (pci_we_vec[s]),
            .pci_idx    (pci_word),
            .pci_data   (pci_data),
            .pci_be     (pci_be),
            .pci_last   (pci_last),
            .mem_we     (mem_valid && (mem_set == 1'(s))),
            .mem_idx    (mem_beat),
            .mem_data   (mem_data),
            .mem_last   (mem_last),
            .fl_we      (fl_valid && (fl_set == 1'(s))),
            .fl_idx     (fl_beat),
            .fl_data    (fl_data),
            .fl_dirty   (fl_dirty),
            .fl_last    (fl_last),
            .wb_ack     (ack_vec[s]),
            .rd_idx     (wb_beat),
            .accepting  (accepting[s]),
            .wb_pending (pending[s]),
            .rd_data    (rd_data[s])
        );
    end

    // Present the set under write-back.
    always_comb begin
        wb_set  = wb_ptr;
        wb_data = rd_data[wb_ptr];
    end

endmodule

// File: rtl/dmb_merge_buf_chk.sv
// Port-level checker for dmb_merge_buf, attached by bind.
module dmb_merge_buf_chk (
    input logic clk,
    input logic rst_n,
    input logic pci_valid,
    input logic pci_ready,
    input logic pci_last,
    input logic fill_set,
    input logic mem_valid,
    input logic fl_valid,
    input logic wb_req,
    input logic wb_set,
    input logic wb_ack
);

    // R1: reset leaves the block idle and ready.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (pci_ready && !wb_req && !fill_set));

    // R5: a request only appears at an edge that captured some load.
    p_req_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_req) |-> $past(mem_valid || fl_valid || (pci_valid && pci_ready)));

    // R6: accepted line end moves the fill set.
    p_fill_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_valid && pci_ready && pci_last) |=> (fill_set != $past(fill_set)));

    // R6: fill set stays put otherwise.
    p_fill_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pci_valid && pci_ready && pci_last) |=> $stable(fill_set));

    // R8: an unacknowledged request holds with the same set.
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_set)));

    // R8: acknowledge passes write-back to the other set.
    p_ack_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ack) |=> (wb_set != $past(wb_set)));

endmodule

bind dmb_merge_buf dmb_merge_buf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pci_valid (pci_valid),
    .pci_ready (pci_ready),
    .pci_last  (pci_last),
    .fill_set  (fill_set),
    .mem_valid (mem_valid),
    .fl_valid  (fl_valid),
    .wb_req    (wb_req),
    .wb_set    (wb_set),
    .wb_ack    (wb_ack)
);

// File: tb/sim_dmb_merge_buf.sv
module sim_dmb_merge_buf;

    localparam int LB = 64;
    localparam int PB = 8;
    localparam int MB = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pci_valid = 0, pci_last = 0, mem_valid = 0, mem_set = 0, mem_last = 0;
    logic fl_valid = 0, fl_set = 0, fl_dirty = 0, fl_last = 0, wb_ack = 0;
    logic [2:0] pci_word = 0;
    logic [63:0] pci_data = 0;
    logic [7:0] pci_be = 0;
    logic mem_beat = 0, fl_beat = 0, wb_beat = 0;
    logic [255:0] mem_data = 0, fl_data = 0, wb_data;
    logic pci_ready, fill_set, wb_req, wb_set;

    int tests = 0, fails = 0;
    bit finished = 0;
    int exp_fill = 0;

    logic [7:0] mp [2][LB];
    logic [7:0] fp [2][LB];
    logic [7:0] pp [2][LB];
    bit         pe [2][LB];
    bit         dy [2];

    always #2 clk = ~clk;

    dmb_merge_buf u0 (.*);

    task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic new_line(int s);
        for (int i = 0; i < LB; i++) begin
            pe[s][i] = 0;
            mp[s][i] = 8'h00;
            fp[s][i] = 8'h00;
        end
        dy[s] = 0;
    endtask

    task automatic pci_send(int w, logic [63:0] d, logic [7:0] be, bit last);
        @(negedge clk);
        while (!pci_ready) @(negedge clk);
        pci_valid = 1; pci_word = 3'(w); pci_data = d; pci_be = be; pci_last = last;
        for (int k = 0; k < PB; k++) if (be[k]) begin
            pp[exp_fill][w*PB+k] = d[k*8 +: 8];
            pe[exp_fill][w*PB+k] = 1;
        end
        @(negedge clk);
        pci_valid = 0; pci_last = 0;
        if (last) exp_fill ^= 1;
    endtask

    task automatic mem_send(int s, int seed, bit model);
        for (int b = 0; b < 2; b++) begin
            logic [255:0] v;
            for (int k = 0; k < MB; k++) begin
                v[k*8 +: 8] = 8'(seed + (b*MB+k)*5);
                if (model) mp[s][b*MB+k] = v[k*8 +: 8];
            end
            @(negedge clk);
            mem_valid = 1; mem_set = s[0]; mem_beat = b[0]; mem_data = v; mem_last = (b == 1);
        end
        @(negedge clk);
        mem_valid = 0; mem_last = 0;
    endtask

    task automatic fl_send(int s, int seed, bit model);
        for (int b = 0; b < 2; b++) begin
            logic [255:0] v;
            for (int k = 0; k < MB; k++) begin
                v[k*8 +: 8] = 8'(seed + (b*MB+k)*7);
                if (model) fp[s][b*MB+k] = v[k*8 +: 8];
            end
            @(negedge clk);
            fl_valid = 1; fl_set = s[0]; fl_beat = b[0]; fl_dirty = 1; fl_data = v; fl_last = (b == 1);
        end
        if (model) dy[s] = 1;
        @(negedge clk);
        fl_valid = 0; fl_last = 0; fl_dirty = 0;
    endtask

    task automatic fl_miss(int s);
        @(negedge clk);
        fl_valid = 1; fl_set = s[0]; fl_dirty = 0; fl_last = 0;
        @(negedge clk);
        fl_valid = 0;
    endtask

    // Checks request, set and both merged beats against the model.
    task automatic verify(int s, string req);
        chk({req, " wb_req"}, 256'(wb_req), 256'(1));
        chk({req, " wb_set"}, 256'(wb_set), 256'(s));
        for (int b = 0; b < 2; b++) begin
            logic [255:0] e;
            for (int k = 0; k < MB; k++) begin
                int i = b*MB + k;
                e[k*8 +: 8] = pe[s][i] ? pp[s][i] : (dy[s] ? fp[s][i] : mp[s][i]);
            end
            wb_beat = b[0];
            #1;
            chk({req, " R10 beat data"}, wb_data, e);
        end
    endtask

    task automatic ack();
        @(negedge clk);
        wb_ack = 1;
        @(negedge clk);
        wb_ack = 0;
    endtask

    task automatic t_reset();
        chk("R1 pci_ready", 256'(pci_ready), 256'(1));
        chk("R1 wb_req", 256'(wb_req), 256'(0));
        chk("R1 fill_set", 256'(fill_set), 256'(0));
    endtask

    task automatic t_partial_miss();
        int s = exp_fill;
        new_line(s);
        pci_send(0, 64'h1122334455667788, 8'h0F, 0);
        pci_send(5, 64'hA1A2A3A4A5A6A7A8, 8'hFF, 1);
        chk("R6 fill toggled", 256'(fill_set), 256'(exp_fill));
        mem_send(s, 8'h20, 1);
        chk("R5 no req before flush", 256'(wb_req), 256'(0));
        fl_miss(s);
        verify(s, "R2 R4 R5");
        ack();
        chk("R8 req cleared", 256'(wb_req), 256'(0));
    endtask

    task automatic t_dirty_flush();
        int s = exp_fill;
        new_line(s);
        pci_send(2, 64'hDEADBEEFCAFEF00D, 8'hF0, 0);
        fl_send(s, 8'h40, 1);
        chk("R5 no req before mem", 256'(wb_req), 256'(0));
        mem_send(s, 8'h90, 1);
        chk("R5 no req before pci_last", 256'(wb_req), 256'(0));
        pci_send(2, 64'h0102030405060708, 8'h3C, 0);
        pci_send(7, 64'h00000000000000EE, 8'h01, 1);
        verify(s, "R2 R3 R5");
        ack();
    endtask

    task automatic t_pingpong();
        int sa = exp_fill;
        int sb = 1 - sa;
        new_line(sa);
        new_line(sb);
        pci_send(0, 64'h5555AAAA5555AAAA, 8'hFF, 1);
        chk("R6 fill to other set", 256'(fill_set), 256'(sb));
        chk("R6 ready for other set", 256'(pci_ready), 256'(1));
        pci_send(1, 64'h7700000000000000, 8'h80, 1);
        chk("R6 fill back", 256'(fill_set), 256'(sa));
        chk("R7 backpressure", 256'(pci_ready), 256'(0));
        mem_send(sb, 8'h33, 1);
        fl_miss(sb);
        chk("R8 in-order no req", 256'(wb_req), 256'(0));
        mem_send(sa, 8'h61, 1);
        fl_send(sa, 8'h0B, 1);
        verify(sa, "R8 first set");
        chk("R7 still full", 256'(pci_ready), 256'(0));
        ack();
        chk("R7 ready after ack", 256'(pci_ready), 256'(1));
        verify(sb, "R8 second set");
        ack();
        chk("R8 idle", 256'(wb_req), 256'(0));
    endtask

    task automatic t_reuse_ignore();
        int s = exp_fill;
        fl_send(s, 8'hC0, 0);
        mem_send(s, 8'h71, 0);
        new_line(s);
        pci_send(3, 64'h9900000000000066, 8'h81, 1);
        chk("R9 no req", 256'(wb_req), 256'(0));
        mem_send(s, 8'h05, 1);
        chk("R9 free-set flush not counted", 256'(wb_req), 256'(0));
        fl_miss(s);
        verify(s, "R8 R9 cleared enables");
        ack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_partial_miss();
        t_dirty_flush();
        t_pingpong();
        t_reuse_ignore();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule